// File: doc/BRIEF.md
# Phase-Accumulator Baud Tick Generator

This block produces the oversampling strobe that paces a serial transmitter and receiver. Software programs a 24-bit increment through a small byte-wide register bus, one byte slice per address. On every cycle in which the timer enable is high, the increment is added into a 24-bit phase accumulator. A single-cycle tick is emitted each time the accumulator's top bit goes from 0 to 1. Eight ticks make up one serial bit, so the increment for a bit rate `baud` on a clock `f_clk` is `baud * 2^27 / f_clk`.

Because the accumulator is fractional, any rate up to one tick per two enabled cycles can be reached with 24-bit resolution and no integer rounding of the divide ratio. Every write to an increment slice also raises a one-cycle flush strobe, which the neighbouring transmit and receive buffers use to discard data sent or received at the old rate. The accumulator itself keeps its phase across a rate change.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset all three increment slices read back 00h, and both `baud_tick` and `fifo_flush` are low.
- R2: Address 0 holds bits 23:16 of the increment, address 1 bits 15:8 and address 2 bits 7:0; each is written alone and read back combinationally on `bus_rdata`; address 3 reads 00h and a write to it changes no slice.
- R3: A write to address 0, 1 or 2 raises `fifo_flush` for exactly the clock cycle after the write edge; reads and writes to address 3 leave it low.
- R4: The accumulator advances only on clock edges where `tmr_en` is high; with `tmr_en` low no tick is produced.
- R5: `baud_tick` is high for exactly one cycle per 0-to-1 transition of the accumulator's top bit and is never high in two consecutive cycles.
- R6: For an increment no larger than 800000h, the number of ticks over N enabled cycles is within one of N * increment / 2^24, so an increment of `baud * 2^27 / f_clk` gives eight ticks per bit time.
- R7: With an increment of zero no tick is produced.
- R8: Writing an increment slice does not clear the accumulator; the phase reached before the write carries on afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Timer enable; accumulator steps on edges where high |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable (with `bus_sel`) |
| bus_addr | input | 2 | Slice address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed slice |
| baud_tick | output | 1 | One-cycle oversampling tick |
| fifo_flush | output | 1 | One-cycle flush strobe after an increment write |

## Verification
The bench builds the block with its default 24-bit increment and 2-bit address, which puts a spare address in reach so the ignored slot can be exercised next to the three live slices. With the full 24-bit width, increments derived from real bit-rate and clock pairs (1/16, 3/8 and 1/2 tick per cycle, and a non-power-of-two fraction) can be counted against their expected ratios in a few thousand cycles. Single stepped enables around a rewrite of the same slice expose whether the accumulator phase survives a write.

// File: rtl/baud_pkg.sv
package baud_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   // Number of byte slices needed for an increment of the given width
   function automatic int unsigned slice_count(input int unsigned width);
      return (width + BYTE_W - 1) / BYTE_W;
   endfunction
endpackage

// File: rtl/baud_inc_regs.sv
module baud_inc_regs
   import baud_pkg::*;
#(
   parameter int unsigned INC_W  = 24,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  byte_t             wdata,
   output byte_t             rdata,
   output logic [INC_W-1:0]  inc,
   output logic              wr_hit
);
   localparam int unsigned NB = slice_count(INC_W);

   logic [NB-1:0] hit;

   // Slice g sits at address NB-1-g: most significant byte at address 0
   for (genvar g = 0; g < NB; g++) begin : g_slice
      localparam int unsigned SLOT = NB - 1 - g;
      byte_t slice_q;

      assign hit[g] = wr_en && (int'(addr) == SLOT);

      always_ff @(posedge clk) begin
         if (!rst_n)      slice_q <= '0;
         else if (hit[g]) slice_q <= wdata;
      end

      assign inc[g*BYTE_W +: BYTE_W] = slice_q;
   end

   always_comb begin
      rdata = '0;
      for (int g = 0; g < NB; g++) begin
         if (int'(addr) == NB - 1 - g) rdata = inc[g*BYTE_W +: BYTE_W];
      end
   end

   assign wr_hit = |hit;
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
   parameter int unsigned ACC_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [ACC_W-1:0] inc,
   output logic             tick
);
   localparam int unsigned MSB = ACC_W - 1;

   logic [ACC_W-1:0] acc_q;
   logic             msb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         msb_q <= 1'b0;
      end else begin
         msb_q <= acc_q[MSB];
         if (step) acc_q <= acc_q + inc;
      end
   end

   // Rising edge of the top bit, one clock wide
   assign tick = acc_q[MSB] & ~msb_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_pkg::*;
#(
   parameter int unsigned INC_W  = 24,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tmr_en,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              baud_tick,
   output logic              fifo_flush
);
   localparam int unsigned NB = slice_count(INC_W);

   initial begin
      assert (INC_W % BYTE_W == 0 && INC_W >= 2 * BYTE_W)
         else $error("INC_W must be a multiple of 8 and at least 16");
      assert ((1 << ADDR_W) >= NB)
         else $error("ADDR_W too narrow for the increment slices");
   end

   logic [INC_W-1:0] inc_val;
   logic             wr_hit;
   logic             flush_q;

   baud_inc_regs #(.INC_W(INC_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_sel & bus_we),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .rdata  (bus_rdata),
      .inc    (inc_val),
      .wr_hit (wr_hit)
   );

   baud_phase_acc #(.ACC_W(INC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (tmr_en),
      .inc   (inc_val),
      .tick  (baud_tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) flush_q <= 1'b0;
      else        flush_q <= wr_hit;
   end

   assign fifo_flush = flush_q;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
   parameter int unsigned INC_W  = 24,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tmr_en,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_rdata,
   input logic              baud_tick,
   input logic              fifo_flush,
   input logic [INC_W-1:0]  inc_val
);
   localparam int unsigned NB = INC_W / 8;

   AST_FLUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && int'(bus_addr) < NB) |=> fifo_flush); // R3
   AST_FLUSH_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_we && int'(bus_addr) < NB) |=> !fifo_flush); // R3
   AST_TICK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |=> !baud_tick); // R5
   AST_TICK_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> $past(tmr_en)); // R4
   AST_ZERO_INC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> ($past(inc_val) != '0)); // R7
   AST_SPARE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_addr) >= NB) |-> (bus_rdata == 8'h00)); // R2
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.INC_W(INC_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tmr_en = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       baud_tick;
   logic       fifo_flush;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   baud_tick_gen u0 (
      .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .bus_sel(bus_sel),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .baud_tick(baud_tick), .fifo_flush(fifo_flush)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_near(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act < exp - 1 || act > exp + 1) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (+/-1)", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // Write one slice; flush checked on the cycle after the write edge
   task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input bit expect_flush);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      check("R3 flush after write", fifo_flush, expect_flush);
      @(negedge clk);
      check("R3 flush one cycle", fifo_flush, 0);
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_inc(input logic [23:0] v);
      bus_write(2'd0, v[23:16], 1'b1);
      bus_write(2'd1, v[15:8], 1'b1);
      bus_write(2'd2, v[7:0], 1'b1);
   endtask

   // Run enabled for n cycles, count ticks, track back-to-back ticks
   task automatic run_count(input int n, output int ticks, output int doubles);
      bit prev = 1'b0;
      ticks = 0; doubles = 0;
      @(negedge clk);
      tmr_en = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (baud_tick) ticks++;
         if (baud_tick && prev) doubles++;
         prev = baud_tick;
      end
      tmr_en = 1'b0;
   endtask

   task automatic single_step(output logic t);
      @(negedge clk);
      tmr_en = 1'b1;
      @(negedge clk);
      tmr_en = 1'b0;
      t = baud_tick;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 tick at reset", baud_tick, 0);
      check("R1 flush at reset", fifo_flush, 0);
      for (int a = 0; a < 3; a++) begin
         bus_read(2'(a), d);
         check("R1 slice reset value", d, 0);
      end
   endtask

   task automatic t_map();
      logic [7:0] d;
      bus_write(2'd0, 8'h12, 1'b1);
      bus_write(2'd1, 8'h34, 1'b1);
      bus_write(2'd2, 8'h56, 1'b1);
      bus_read(2'd0, d); check("R2 upper slice", d, 8'h12);
      bus_read(2'd1, d); check("R2 middle slice", d, 8'h34);
      bus_read(2'd2, d); check("R2 lower slice", d, 8'h56);
      bus_write(2'd1, 8'hA5, 1'b1);
      bus_read(2'd0, d); check("R2 upper kept", d, 8'h12);
      bus_read(2'd1, d); check("R2 middle rewritten", d, 8'hA5);
      bus_write(2'd3, 8'hFF, 1'b0);
      bus_read(2'd3, d); check("R2 spare reads zero", d, 0);
      bus_read(2'd0, d); check("R2 spare write ignored upper", d, 8'h12);
      bus_read(2'd1, d); check("R2 spare write ignored middle", d, 8'hA5);
      bus_read(2'd2, d); check("R2 spare write ignored lower", d, 8'h56);
      @(negedge clk);
      check("R3 no flush on read", fifo_flush, 0);
   endtask

   task automatic t_zero();
      int t, dbl;
      set_inc(24'h000000);
      run_count(500, t, dbl);
      check("R7 zero increment ticks", t, 0);
   endtask

   task automatic t_hold();
      int t = 0;
      set_inc(24'h400000);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (baud_tick) t++;
      end
      check("R4 no tick while disabled", t, 0);
   endtask

   // Accumulator is 0 here; increment is quarter scale
   task automatic t_keep();
      logic t;
      single_step(t);
      check("R8 first step below half", t, 0);
      bus_write(2'd0, 8'h40, 1'b1);
      single_step(t);
      check("R8 phase kept across write", t, 1);
      @(negedge clk);
      check("R5 tick one cycle wide", baud_tick, 0);
   endtask

   task automatic t_rate(input string tag, input longint baud, input longint fclk, input int n);
      int t, dbl;
      longint inc = (baud * (longint'(1) << 27)) / fclk;
      set_inc(24'(inc));
      run_count(n, t, dbl);
      check_near({"R6 rate ", tag}, t, (longint'(n) * inc) >> 24);
      check({"R5 no back-to-back ticks ", tag}, dbl, 0);
   endtask

   task automatic t_raw(input string tag, input logic [23:0] inc, input int n);
      int t, dbl;
      set_inc(inc);
      run_count(n, t, dbl);
      check_near({"R6 rate ", tag}, t, (longint'(n) * inc) >> 24);
      check({"R5 no back-to-back ticks ", tag}, dbl, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_zero();
      t_hold();
      t_keep();
      t_rate("1/16", 64'd9600, 64'd1228800, 3200);
      t_rate("3/8", 64'd57600, 64'd1228800, 3000);
      t_raw("half", 24'h800000, 2000);
      t_raw("odd", 24'h0A3D71, 3000);
      done = 1'b1;
      report();
   end
endmodule